// File: doc/BRIEF.md
# Decoupled Register Access Engine

This block lets a host read or write one 32-bit register inside a power-gated target domain without waking the domain itself. The host sees three registers on a simple register bus: a data mailbox, a control mailbox and a status word. A command word carries the target offset, an operation code and a domain number. Writing that word with its GO bit set starts the engine. The engine raises the wake request of the chosen domain and waits for its acknowledge. It then performs the single target access, drops the wake request and clears GO. The host only polls GO.

Wider values are moved as separate one-dword commands at offset and offset+4. Nothing makes such a pair atomic. If a domain never acknowledges, or the target never answers, a watchdog of `TMO_CYCLES` cycles per wait phase aborts the command and leaves a sticky flag.

The target request channel uses valid/ready. While `tgt_req_valid` is high and `tgt_req_ready` is low, the engine holds the request and keeps `tgt_req_write`, `tgt_req_addr` and `tgt_req_wdata` stable. The request is accepted in the cycle where both are high. The read response channel has no ready signal. The engine takes `tgt_rsp_valid` only while it waits for a read response and ignores it at any other time.

Top module: `dwacc_engine`

## Requirements
- R1: After reset, the data and control mailboxes and the status word read zero, GO is clear, no wake request is driven and `tgt_req_valid` is low.
- R2: Host register map by `host_addr`:
  - 0 is data.
  - 1 is control. It reads back as the stored bits [30:0] with the live GO state in bit 31.
  - 2 is status. Bit 0 is timeout and bit 1 is bad command.
  - 3 reads zero.
  
  A control write with bit 31 clear stores the word and starts nothing.
- R3: The control word fields are offset [22:0], operation [25:24] (0 read, 1 write) and domain [29:28] (valid IDs 1..3). When idle, a valid control write with bit 31 set makes GO read 1 from the next cycle. In that same next cycle, it raises `wake_req[domain-1]` and only that bit.
- R4: `tgt_req_valid` rises only after the selected domain's acknowledge has been seen. While it is not accepted, it holds the request with stable write, address and data.
- R5: The wake request stays high through the target access. It drops in the same cycle GO clears, and that happens only after a write is accepted or a read response arrives.
- R6: For a read, the response data is in the data mailbox by the time GO reads 0.
- R7: For a write, the target receives the data mailbox contents at the command's offset with `tgt_req_write` high.
- R8: A GO command with domain 0 or operation 2 or 3 raises no wake request and leaves GO at 0. It sets status bit 1.
- R9: If any wait phase runs for `TMO_CYCLES` cycles without progress, the engine aborts. The phases are acknowledge, request acceptance and read response. On abort, GO and the wake request drop and status bit 0 is set.
- R10: Status bits are sticky. Writing 1 to a bit clears it and writing 0 leaves it.
- R11: While GO is set, host writes to the data and control mailboxes have no effect.
- R12: Each command causes exactly one accepted target request. Two dwords need two commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| wake_req | output | 3 | Wake request, bit i for domain i+1 |
| wake_ack | input | 3 | Wake acknowledge, bit i for domain i+1 |
| tgt_req_valid | output | 1 | Target request valid |
| tgt_req_ready | input | 1 | Target accepts request |
| tgt_req_write | output | 1 | 1 = write access |
| tgt_req_addr | output | 23 | Target register offset |
| tgt_req_wdata | output | 32 | Write payload |
| tgt_rsp_valid | input | 1 | Read response valid |
| tgt_rsp_data | input | 32 | Read response data |

## Verification
The bench targets several corner cases, each with a distinct failure signature:

- **Slow acknowledge and back-pressured acceptance.** A design that issued the request before the acknowledge, or released the wake request at acceptance of a read, would show a target request with no wake, or GO clearing early.
- **Mailbox writes during a busy command.** A design that let these through would send a corrupted payload or offset to the target.
- **Bad domain and bad operation codes.** A design that failed to reject them would raise a wake request for a nonexistent domain or hang with GO set.
- **Silent domain and silent read target.** A missing watchdog would leave GO stuck high. A watchdog that did not clear its count per phase would abort too early.

A cycle-level behavioural model flags any of these in the first cycle where an output differs.

// File: rtl/dwacc_pkg.sv
package dwacc_pkg;
  localparam int OFF_W   = 23;
  localparam int OP_LSB  = 24;
  localparam int OP_W    = 2;
  localparam int DOM_LSB = 28;
  localparam int DOM_W   = 2;
  localparam int GO_BIT  = 31;
  localparam int DOM_CNT = (1 << DOM_W) - 1;

  localparam logic [OP_W-1:0] OP_RD = 2'd0;
  localparam logic [OP_W-1:0] OP_WR = 2'd1;

  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WAKE  = 2'd1,
    SQ_ISSUE = 2'd2,
    SQ_RESP  = 2'd3
  } sq_state_e;
endpackage

// File: rtl/dwacc_mailbox.sv
module dwacc_mailbox
  import dwacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel,
  input  logic             host_wr,
  input  logic [1:0]       host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic             seq_finish,
  input  logic             seq_abort,
  input  logic             rd_load,
  input  logic [31:0]      rd_data,
  output logic             start,
  output logic             go,
  output logic [OFF_W-1:0] cmd_off,
  output logic [OP_W-1:0]  cmd_op,
  output logic [DOM_W-1:0] cmd_dom,
  output logic [31:0]      data_q
);
  logic [30:0] ctrl_q;
  logic        go_q, tmo_q, bad_q;
  logic        wr_data, wr_ctrl, wr_stat, launch, cmd_ok, reject;
  logic [OP_W-1:0]  w_op;
  logic [DOM_W-1:0] w_dom;

  assign wr_data = host_sel && host_wr && (host_addr == RA_DATA);
  assign wr_ctrl = host_sel && host_wr && (host_addr == RA_CTRL);
  assign wr_stat = host_sel && host_wr && (host_addr == RA_STAT);
  assign w_op    = host_wdata[OP_LSB +: OP_W];
  assign w_dom   = host_wdata[DOM_LSB +: DOM_W];
  assign launch  = wr_ctrl && !go_q && host_wdata[GO_BIT];
  assign cmd_ok  = (w_dom != '0) && ((w_op == OP_RD) || (w_op == OP_WR));
  assign start   = launch && cmd_ok;
  assign reject  = launch && !cmd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      go_q   <= 1'b0;
      tmo_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      if (rd_load)
        data_q <= rd_data;
      else if (wr_data && !go_q)
        data_q <= host_wdata;
      if (wr_ctrl && !go_q)
        ctrl_q <= host_wdata[30:0];
      if (start)
        go_q <= 1'b1;
      else if (seq_finish || seq_abort)
        go_q <= 1'b0;
      if (seq_abort)
        tmo_q <= 1'b1;
      else if (wr_stat && host_wdata[0])
        tmo_q <= 1'b0;
      if (reject)
        bad_q <= 1'b1;
      else if (wr_stat && host_wdata[1])
        bad_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (host_addr)
      RA_DATA: host_rdata = data_q;
      RA_CTRL: host_rdata = {go_q, ctrl_q};
      RA_STAT: host_rdata = {30'd0, bad_q, tmo_q};
      default: host_rdata = '0;
    endcase
  end

  assign go      = go_q;
  assign cmd_off = ctrl_q[OFF_W-1:0];
  assign cmd_op  = ctrl_q[OP_LSB +: OP_W];
  assign cmd_dom = ctrl_q[DOM_LSB +: DOM_W];

  // R11
  busy_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && wr_data && !rd_load) |=> $stable(data_q));
  // R11
  busy_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && wr_ctrl) |=> $stable(ctrl_q));
  // R8
  bad_cmd_no_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (!go_q && bad_q));
endmodule

// File: rtl/dwacc_wdog.sv
module dwacc_wdog #(
  parameter int TMO_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic progress,
  output logic expire
);
  localparam int CW = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && !progress && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || progress || expire)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  // R9
  wdog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/dwacc_sequencer.sv
module dwacc_sequencer
  import dwacc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DOM_W-1:0]   dom,
  input  logic [OP_W-1:0]    op,
  input  logic [DOM_CNT-1:0] wake_ack,
  input  logic               tgt_req_ready,
  input  logic               tgt_rsp_valid,
  input  logic               expire,
  output logic [DOM_CNT-1:0] wake_req,
  output logic               tgt_req_valid,
  output logic               tgt_req_write,
  output logic               finish,
  output logic               abort,
  output logic               rd_load,
  output logic               run,
  output logic               progress
);
  sq_state_e st_q, st_d;
  logic [DOM_CNT-1:0] dom_sel;
  logic ack_sel, is_wr;

  for (genvar i = 0; i < DOM_CNT; i++) begin : g_dsel
    assign dom_sel[i] = (dom == DOM_W'(i + 1));
  end

  assign is_wr         = (op == OP_WR);
  assign run           = (st_q != SQ_IDLE);
  assign wake_req      = run ? dom_sel : '0;
  assign ack_sel       = |(wake_ack & dom_sel);
  assign tgt_req_valid = (st_q == SQ_ISSUE);
  assign tgt_req_write = is_wr;

  always_comb begin
    unique case (st_q)
      SQ_WAKE:  progress = ack_sel;
      SQ_ISSUE: progress = tgt_req_ready;
      SQ_RESP:  progress = tgt_rsp_valid;
      default:  progress = 1'b0;
    endcase
  end

  assign rd_load = (st_q == SQ_RESP) && tgt_rsp_valid;
  assign finish  = rd_load || ((st_q == SQ_ISSUE) && tgt_req_ready && is_wr);
  assign abort   = expire;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:  if (start) st_d = SQ_WAKE;
      SQ_WAKE:  if (expire) st_d = SQ_IDLE;
                else if (ack_sel) st_d = SQ_ISSUE;
      SQ_ISSUE: if (expire) st_d = SQ_IDLE;
                else if (tgt_req_ready) st_d = is_wr ? SQ_IDLE : SQ_RESP;
      SQ_RESP:  if (expire || tgt_rsp_valid) st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req_valid && !tgt_req_ready && !expire) |=> (tgt_req_valid && $stable(tgt_req_write)));
  // R4
  req_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_req_valid) |-> $past(ack_sel));
  // R12
  single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req_valid && tgt_req_ready) |=> !tgt_req_valid);
  // R3
  wake_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_req));
endmodule

// File: rtl/dwacc_engine.sv
module dwacc_engine
  import dwacc_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic [1:0]         host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic [DOM_CNT-1:0] wake_req,
  input  logic [DOM_CNT-1:0] wake_ack,
  output logic               tgt_req_valid,
  input  logic               tgt_req_ready,
  output logic               tgt_req_write,
  output logic [OFF_W-1:0]   tgt_req_addr,
  output logic [31:0]        tgt_req_wdata,
  input  logic               tgt_rsp_valid,
  input  logic [31:0]        tgt_rsp_data
);
  logic start, go, finish, abort, rd_load, run, progress, expire;
  logic [OFF_W-1:0] cmd_off;
  logic [OP_W-1:0]  cmd_op;
  logic [DOM_W-1:0] cmd_dom;
  logic [31:0]      data_q;

  dwacc_mailbox u_mbox (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .seq_finish(finish), .seq_abort(abort),
    .rd_load(rd_load), .rd_data(tgt_rsp_data),
    .start(start), .go(go),
    .cmd_off(cmd_off), .cmd_op(cmd_op), .cmd_dom(cmd_dom),
    .data_q(data_q)
  );

  dwacc_sequencer u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .dom(cmd_dom), .op(cmd_op),
    .wake_ack(wake_ack), .tgt_req_ready(tgt_req_ready),
    .tgt_rsp_valid(tgt_rsp_valid), .expire(expire),
    .wake_req(wake_req), .tgt_req_valid(tgt_req_valid),
    .tgt_req_write(tgt_req_write),
    .finish(finish), .abort(abort), .rd_load(rd_load),
    .run(run), .progress(progress)
  );

  dwacc_wdog #(.TMO_CYCLES(TMO_CYCLES)) u_wdog (
    .clk(clk), .rst_n(rst_n),
    .run(run), .progress(progress), .expire(expire)
  );

  assign tgt_req_addr  = cmd_off;
  assign tgt_req_wdata = data_q;

  // R5
  wake_implies_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake_req) |-> go);
  // R5
  wake_drop_with_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go) |-> (wake_req == '0));
  // R4
  req_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req_valid && !tgt_req_ready && !expire) |=> ($stable(tgt_req_addr) && $stable(tgt_req_wdata)));
endmodule

// File: tb/dwacc_engine_bench.sv
module dwacc_engine_bench;
  localparam int TMO = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [2:0]  wake_req;
  logic [2:0]  wake_ack = '0;
  logic        tgt_req_valid, tgt_req_write;
  logic        tgt_req_ready = 1'b0;
  logic [22:0] tgt_req_addr;
  logic [31:0] tgt_req_wdata;
  logic        tgt_rsp_valid = 1'b0;
  logic [31:0] tgt_rsp_data = '0;

  always #4 clk = ~clk;

  dwacc_engine #(.TMO_CYCLES(TMO)) u_dwacc_engine (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .wake_req(wake_req), .wake_ack(wake_ack),
    .tgt_req_valid(tgt_req_valid), .tgt_req_ready(tgt_req_ready),
    .tgt_req_write(tgt_req_write), .tgt_req_addr(tgt_req_addr),
    .tgt_req_wdata(tgt_req_wdata),
    .tgt_rsp_valid(tgt_rsp_valid), .tgt_rsp_data(tgt_rsp_data)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- target responder ----------------
  bit ack_en = 1, rdy_en = 1, rsp_en = 1;
  int ack_dly = 1, rdy_dly = 0;
  int ack_cnt[3];
  int rdy_cnt = 0;
  bit pend = 0;
  logic [22:0] pend_addr;
  int accepts = 0;
  logic [31:0] tmem [int];

  function automatic logic [31:0] rhash(input logic [22:0] a);
    return {a[7:0], a} ^ 32'hC3A5_1E0F;
  endfunction

  always @(posedge clk) begin
    if (tgt_req_valid && tgt_req_ready) begin
      accepts++;
      if (tgt_req_write) tmem[int'(tgt_req_addr)] = tgt_req_wdata;
      else begin pend = 1; pend_addr = tgt_req_addr; end
    end else if (tgt_rsp_valid) pend = 0;
  end

  always @(negedge clk) begin
    #1;
    for (int i = 0; i < 3; i++) begin
      ack_cnt[i] = wake_req[i] ? ack_cnt[i] + 1 : 0;
      wake_ack[i] = ack_en && (ack_cnt[i] > ack_dly);
    end
    rdy_cnt = tgt_req_valid ? rdy_cnt + 1 : 0;
    tgt_req_ready = rdy_en && (rdy_cnt > rdy_dly);
    tgt_rsp_valid = pend && rsp_en;
    tgt_rsp_data  = pend ? rhash(pend_addr) : 32'hFFFF_FFFF;
  end

  // ---------------- behavioural reference model ----------------
  int m_state = 0, m_cnt = 0;
  bit m_go = 0, m_tmo = 0, m_bad = 0;
  logic [31:0] m_data = '0;
  logic [30:0] m_ctrl = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_go = 0; m_tmo = 0; m_bad = 0;
      m_data = '0; m_ctrl = '0;
    end else begin
      int dom, op, nstate;
      bit prog, exp_t, done;
      bit old_go;
      old_go = m_go;
      dom = int'(m_ctrl[29:28]);
      op  = int'(m_ctrl[25:24]);
      prog = 0; done = 0; nstate = m_state;
      case (m_state)
        1: prog = (dom > 0) && wake_ack[dom-1];
        2: prog = tgt_req_ready;
        3: prog = tgt_rsp_valid;
        default: prog = 0;
      endcase
      exp_t = (m_state != 0) && !prog && (m_cnt == TMO - 1);
      if (exp_t) begin nstate = 0; m_tmo = 1; m_go = 0; end
      else if (m_state == 1 && prog) nstate = 2;
      else if (m_state == 2 && prog) begin
        if (op == 1) begin nstate = 0; done = 1; end else nstate = 3;
      end else if (m_state == 3 && prog) begin
        nstate = 0; done = 1; m_data = tgt_rsp_data;
      end
      if (done) m_go = 0;
      m_cnt = ((m_state == 0) || prog || exp_t) ? 0 : m_cnt + 1;
      if (host_sel && host_wr) begin
        if (host_addr == 2'd0 && !old_go) m_data = host_wdata;
        if (host_addr == 2'd1 && !old_go) begin
          m_ctrl = host_wdata[30:0];
          if (host_wdata[31]) begin
            if (host_wdata[29:28] == 0 || host_wdata[25:24] > 1) m_bad = 1;
            else begin m_go = 1; nstate = 1; m_cnt = 0; end
          end
        end
        if (host_addr == 2'd2) begin
          if (host_wdata[0] && !exp_t) m_tmo = 0;
          if (host_wdata[1]) m_bad = 0;
        end
      end
      m_state = nstate;
    end
  end

  // per-cycle comparison, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0]  ew;
      logic [31:0] er;
      int dom;
      dom = int'(m_ctrl[29:28]);
      ew = (m_state != 0 && dom > 0) ? 3'(1 << (dom - 1)) : 3'b000;
      chk(wake_req === ew, "R5 wake_req", {29'd0, wake_req}, {29'd0, ew});
      chk(tgt_req_valid === (m_state == 2), "R4 tgt_req_valid", {31'd0, tgt_req_valid}, {31'd0, m_state == 2});
      if (m_state == 2) begin
        chk(tgt_req_write === (m_ctrl[25:24] == 1), "R7 tgt_req_write", {31'd0, tgt_req_write}, {31'd0, m_ctrl[25:24] == 1});
        chk(tgt_req_addr === m_ctrl[22:0], "R7 tgt_req_addr", {9'd0, tgt_req_addr}, {9'd0, m_ctrl[22:0]});
        chk(tgt_req_wdata === m_data, "R7 tgt_req_wdata", tgt_req_wdata, m_data);
      end
      case (host_addr)
        2'd0: er = m_data;
        2'd1: er = {m_go, m_ctrl};
        2'd2: er = {30'd0, m_bad, m_tmo};
        default: er = '0;
      endcase
      chk(host_rdata === er, "R2 host_rdata", host_rdata, er);
    end
  end

  // ---------------- host tasks ----------------
  task automatic hwr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); #1;
    host_sel = 0; host_wr = 0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    host_sel = 1; host_wr = 0; host_addr = a;
    @(negedge clk);
    d = host_rdata;
    #1 host_sel = 0;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    int n = 0;
    do begin hrd(2'd1, v); n++; end while (v[31] && n < 200);
    chk(v[31] == 0, tag, v, {1'b0, v[30:0]});
  endtask

  function automatic logic [31:0] cw(input bit go, input int dom, input int op, input logic [22:0] off);
    return {go, 1'b0, 2'(dom), 2'd0, 2'(op), 1'b0, off};
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int acc0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    hrd(2'd0, v); chk(v == 0, "R1 data", v, 0);
    hrd(2'd1, v); chk(v == 0, "R1 ctrl", v, 0);
    hrd(2'd2, v); chk(v == 0, "R1 status", v, 0);
    chk(wake_req == 0 && !tgt_req_valid, "R1 idle outputs", {28'd0, wake_req, tgt_req_valid}, 0);

    // R2: control write without GO stores only
    hwr(2'd1, cw(0, 2, 1, 23'h0123));
    repeat (3) @(negedge clk);
    chk(wake_req == 0, "R2 no launch", {29'd0, wake_req}, 0);
    hrd(2'd1, v); chk(v == cw(0, 2, 1, 23'h0123), "R2 ctrl readback", v, cw(0, 2, 1, 23'h0123));
    hrd(2'd3, v); chk(v == 0, "R2 unmapped", v, 0);

    // R3/R7: write to domain 1, slow ack
    ack_dly = 3;
    hwr(2'd0, 32'hA5A5_0001);
    hwr(2'd1, cw(0, 1, 1, 23'h0040));
    @(negedge clk); #1;
    host_sel = 1; host_wr = 1; host_addr = 2'd1; host_wdata = cw(1, 1, 1, 23'h0040);
    @(negedge clk);
    chk(wake_req == 3'b001, "R3 wake for domain 1", {29'd0, wake_req}, 1);
    chk(host_rdata[31] == 1, "R3 GO live", host_rdata, 32'h8000_0000);
    #1 host_sel = 0; host_wr = 0;
    wait_idle("R5 write completes");
    chk(tmem.exists(32'h40) && tmem[32'h40] == 32'hA5A5_0001, "R7 target write data",
        tmem.exists(32'h40) ? tmem[32'h40] : 32'hX, 32'hA5A5_0001);

    // R6/R4: read from domain 2 with back-pressure
    ack_dly = 0; rdy_dly = 4;
    hwr(2'd1, cw(0, 2, 0, 23'h0777));
    hwr(2'd1, cw(1, 2, 0, 23'h0777));
    wait_idle("R5 read completes");
    hrd(2'd0, v); chk(v == rhash(23'h0777), "R6 read data", v, rhash(23'h0777));

    // R11: mailbox writes while busy are ignored
    rdy_dly = 6;
    hwr(2'd0, 32'h1111_2222);
    hwr(2'd1, cw(1, 3, 1, 23'h0100));
    hwr(2'd0, 32'hDEAD_BEEF);
    hwr(2'd1, cw(1, 1, 1, 23'h0200));
    wait_idle("R11 busy command completes");
    chk(tmem.exists(32'h100) && tmem[32'h100] == 32'h1111_2222, "R11 payload untouched",
        tmem.exists(32'h100) ? tmem[32'h100] : 32'hX, 32'h1111_2222);
    chk(!tmem.exists(32'h200), "R11 no second command", 0, 0);
    hrd(2'd0, v); chk(v == 32'h1111_2222, "R11 data readback", v, 32'h1111_2222);
    hrd(2'd1, v); chk(v == cw(0, 3, 1, 23'h0100), "R11 ctrl readback", v, cw(0, 3, 1, 23'h0100));
    rdy_dly = 0;

    // R8: bad domain and bad op
    hwr(2'd1, cw(1, 0, 1, 23'h0008));
    @(negedge clk);
    chk(wake_req == 0, "R8 no wake for domain 0", {29'd0, wake_req}, 0);
    hrd(2'd2, v); chk(v == 32'h2, "R8 bad flag", v, 2);
    hrd(2'd1, v); chk(v[31] == 0, "R8 GO clear", v, {1'b0, v[30:0]});
    // R10: W1C and sticky
    hwr(2'd2, 32'h0);
    hrd(2'd2, v); chk(v == 32'h2, "R10 write 0 keeps", v, 2);
    hwr(2'd2, 32'h2);
    hrd(2'd2, v); chk(v == 0, "R10 write 1 clears", v, 0);
    hwr(2'd1, cw(1, 2, 3, 23'h0008));
    hrd(2'd2, v); chk(v == 32'h2, "R8 bad op", v, 2);
    hwr(2'd2, 32'h2);

    // R9: acknowledge never arrives
    ack_en = 0;
    hwr(2'd1, cw(1, 3, 0, 23'h0010));
    wait_idle("R9 ack timeout aborts");
    chk(wake_req == 0, "R9 wake dropped", {29'd0, wake_req}, 0);
    hrd(2'd2, v); chk(v == 32'h1, "R9 timeout flag", v, 1);
    hrd(2'd2, v); chk(v == 32'h1, "R10 flag sticky", v, 1);
    hwr(2'd2, 32'h1);
    hrd(2'd2, v); chk(v == 0, "R10 timeout cleared", v, 0);
    ack_en = 1;

    // R9: read response never arrives
    rsp_en = 0;
    hwr(2'd1, cw(1, 1, 0, 23'h0020));
    wait_idle("R9 response timeout aborts");
    hrd(2'd2, v); chk(v == 32'h1, "R9 timeout in response wait", v, 1);
    pend = 0; rsp_en = 1;
    hwr(2'd2, 32'h1);

    // R12: two dwords are two commands, one accept each
    acc0 = accepts;
    hwr(2'd0, 32'h0000_CAFE);
    hwr(2'd1, cw(1, 2, 1, 23'h0300));
    wait_idle("R12 low dword");
    chk(accepts == acc0 + 1, "R12 one accept", accepts, acc0 + 1);
    hwr(2'd0, 32'hBEEF_0000);
    hwr(2'd1, cw(1, 2, 1, 23'h0304));
    wait_idle("R12 high dword");
    chk(accepts == acc0 + 2, "R12 second accept", accepts, acc0 + 2);
    chk(tmem.exists(32'h304) && tmem[32'h304] == 32'hBEEF_0000, "R12 high dword data",
        tmem.exists(32'h304) ? tmem[32'h304] : 32'hX, 32'hBEEF_0000);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule